// File: doc/BRIEF.md
# Baseline 12-bit Instruction Execute Unit

This block takes one 12-bit instruction word per clock and carries out its data operation. It combines the instruction with the working register (W), the byte read from the file location the instruction addresses, and the carry flag. From these it forms an 8-bit result, a write strobe, and a destination select that sends the result either to W or back to the file. It covers the byte-oriented, bit-oriented and literal groups of a fixed opcode map.

Program-counter changes, the return stack, instruction fetch and the register file itself belong to the surrounding core. The datapath is combinational. A thin registered shell holds W and the zero and carry flags, so the unit can be driven one instruction per clock. Any encoding the unit does not recognise leaves all of that state alone.

Top module: `exu_top`

## Requirements
- R1: While `rst_n` is low, W, zero and carry all hold 0, and instruction word 0x000 produces no write.
- R2: `file_addr` always equals instruction bits 4..0. For byte operations, bit 5 selects the destination: 0 sends the result to W and 1 writes it to the file (`wr_en`=1 and `to_file`=1). A file write leaves W unchanged.
- R3: Opcode 000010 (bits 11..6) produces f minus W, with carry=1 exactly when f >= W. Opcode 000111 produces f plus W, with carry set to the carry out of bit 7. Both set zero to (result == 0).
- R4: These opcodes set zero to (result == 0) and leave carry unchanged: 000011 (f-1), 000100 (f OR W), 000101 (f AND W), 000110 (f XOR W), 001000 (f), 001001 (NOT f) and 001010 (f+1).
- R5: Opcode 001100 rotates {carry, f} right by one, and the old f bit 0 becomes carry. Opcode 001101 rotates left, with the old carry entering bit 0 and the old f bit 7 becoming carry. Zero is unchanged.
- R6: Opcode 001110 produces f with its upper and lower nibbles exchanged and leaves both flags unchanged.
- R7: Word 0000001fffff writes W to file f, with no flag change. Word 0000010xxxxx clears W and sets zero, whatever bits 4..0 hold. Word 0000011fffff writes 0 to file f and sets zero.
- R8: Bits 11..8 = 0100 clear, and 0101 set, the bit selected by bits 7..5 of f. The result is written to the file, and W and both flags are unchanged.
- R9: Bits 11..8 = 1100, 1101, 1110 and 1111 load W with k, k OR W, k AND W and k XOR W, where k is bits 7..0. The last three set zero to (result == 0). None of the four changes carry.
- R10: Every other encoding leaves `wr_en`=0 and leaves W and both flags unchanged. This includes bits 11..6 = 000000 with bit 5 = 0, 001011, 001111, bits 11..8 = 0110, 0111 and 1000..1011.
- R11: The result outputs are combinational in the same cycle. W, zero and carry take their new values at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | 12 | Instruction word executed this cycle |
| file_rd | input | 8 | Byte read from the addressed file location |
| file_addr | output | 5 | File address taken from the instruction |
| res | output | 8 | Operation result |
| wr_en | output | 1 | Result is written this cycle |
| to_file | output | 1 | 1 sends the result to the file, 0 to W |
| w_out | output | 8 | Registered working register |
| z_out | output | 1 | Registered zero flag |
| c_out | output | 1 | Registered carry flag |

## Verification
The bench builds the block with the package widths: an 8-bit datum, a 5-bit file address and a 3-bit bit index. These widths are small enough that a few thousand uniformly random 12-bit words, paired with random operand bytes, reach every opcode, both destinations, every bit index and all the unassigned encodings many times over. They also reach the carry edges: equal operands in subtraction, sums that wrap past 255, and rotations with either carry value. A directed prologue first pins the exact zero-result and borrow cases before the random run.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int IW = 12;
    localparam int DW = 8;
    localparam int AW = 5;
    localparam int BW = 3;
    localparam int OPW = IW - AW;   // opcode/destination field width

    typedef enum logic [4:0] {
        OP_NONE, OP_SUB, OP_DEC, OP_OR, OP_AND, OP_XOR, OP_ADD, OP_MOV,
        OP_COM, OP_INC, OP_RR, OP_RL, OP_SWAP, OP_PASSW, OP_ZERO,
        OP_BCLR, OP_BSET, OP_LMOV, OP_LOR, OP_LAND, OP_LXOR
    } exu_op_e;

    typedef struct packed {
        exu_op_e op;
        logic    wr_en;
        logic    to_file;
        logic    z_upd;
        logic    c_upd;
    } exu_ctl_t;

    typedef struct packed {
        logic [DW-1:0] w;
        logic          z;
        logic          c;
    } exu_arch_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPW-1:0] opc,   // instruction bits 11..5
    output exu_ctl_t       ctl
);
    logic dsel;
    assign dsel = opc[0];

    always_comb begin
        ctl = '{op: OP_NONE, wr_en: 1'b0, to_file: 1'b0, z_upd: 1'b0, c_upd: 1'b0};
        casez (opc)
            7'b0000001: ctl = '{op: OP_PASSW, wr_en: 1'b1, to_file: 1'b1, z_upd: 1'b0, c_upd: 1'b0};
            7'b000001?: ctl = '{op: OP_ZERO,  wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b000010?: ctl = '{op: OP_SUB,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b1};
            7'b000011?: ctl = '{op: OP_DEC,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b000100?: ctl = '{op: OP_OR,    wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b000101?: ctl = '{op: OP_AND,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b000110?: ctl = '{op: OP_XOR,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b000111?: ctl = '{op: OP_ADD,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b1};
            7'b001000?: ctl = '{op: OP_MOV,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b001001?: ctl = '{op: OP_COM,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b001010?: ctl = '{op: OP_INC,   wr_en: 1'b1, to_file: dsel, z_upd: 1'b1, c_upd: 1'b0};
            7'b001100?: ctl = '{op: OP_RR,    wr_en: 1'b1, to_file: dsel, z_upd: 1'b0, c_upd: 1'b1};
            7'b001101?: ctl = '{op: OP_RL,    wr_en: 1'b1, to_file: dsel, z_upd: 1'b0, c_upd: 1'b1};
            7'b001110?: ctl = '{op: OP_SWAP,  wr_en: 1'b1, to_file: dsel, z_upd: 1'b0, c_upd: 1'b0};
            7'b0100???: ctl = '{op: OP_BCLR,  wr_en: 1'b1, to_file: 1'b1, z_upd: 1'b0, c_upd: 1'b0};
            7'b0101???: ctl = '{op: OP_BSET,  wr_en: 1'b1, to_file: 1'b1, z_upd: 1'b0, c_upd: 1'b0};
            7'b1100???: ctl = '{op: OP_LMOV,  wr_en: 1'b1, to_file: 1'b0, z_upd: 1'b0, c_upd: 1'b0};
            7'b1101???: ctl = '{op: OP_LOR,   wr_en: 1'b1, to_file: 1'b0, z_upd: 1'b1, c_upd: 1'b0};
            7'b1110???: ctl = '{op: OP_LAND,  wr_en: 1'b1, to_file: 1'b0, z_upd: 1'b1, c_upd: 1'b0};
            7'b1111???: ctl = '{op: OP_LXOR,  wr_en: 1'b1, to_file: 1'b0, z_upd: 1'b1, c_upd: 1'b0};
            default: ;
        endcase
    end

    // R8
    bit_dest_chk: assert final ((opc[OPW-1:OPW-3] != 3'b010) || ctl.to_file || !ctl.wr_en);
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
(
    input  exu_op_e       op,
    input  logic [DW-1:0] opnd_f,
    input  logic [DW-1:0] opnd_w,
    input  logic [DW-1:0] lit,
    input  logic [BW-1:0] bit_sel,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          c_res
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] bit_mask;
    logic [DW:0]   sum_x;
    logic [DW:0]   diff_x;

    for (genvar gi = 0; gi < DW; gi++) begin : g_mask
        assign bit_mask[gi] = (bit_sel == BW'(gi));
    end

    assign sum_x  = {1'b0, opnd_f} + {1'b0, opnd_w};
    assign diff_x = {1'b0, opnd_f} - {1'b0, opnd_w};

    always_comb begin
        res   = '0;
        c_res = c_in;
        case (op)
            OP_SUB:   begin res = diff_x[DW-1:0]; c_res = ~diff_x[DW]; end
            OP_ADD:   begin res = sum_x[DW-1:0];  c_res = sum_x[DW];   end
            OP_DEC:   res = opnd_f - DW'(1);
            OP_INC:   res = opnd_f + DW'(1);
            OP_OR:    res = opnd_f | opnd_w;
            OP_AND:   res = opnd_f & opnd_w;
            OP_XOR:   res = opnd_f ^ opnd_w;
            OP_MOV:   res = opnd_f;
            OP_COM:   res = ~opnd_f;
            OP_RR:    begin res = {c_in, opnd_f[DW-1:1]}; c_res = opnd_f[0];    end
            OP_RL:    begin res = {opnd_f[DW-2:0], c_in}; c_res = opnd_f[DW-1]; end
            OP_SWAP:  res = {opnd_f[HALF-1:0], opnd_f[DW-1:HALF]};
            OP_PASSW: res = opnd_w;
            OP_ZERO:  res = '0;
            OP_BCLR:  res = opnd_f & ~bit_mask;
            OP_BSET:  res = opnd_f | bit_mask;
            OP_LMOV:  res = lit;
            OP_LOR:   res = lit | opnd_w;
            OP_LAND:  res = lit & opnd_w;
            OP_LXOR:  res = lit ^ opnd_w;
            default:  res = '0;
        endcase
    end

    // R6
    swap_nibble_chk: assert final ((op != OP_SWAP) || ((res ^ {opnd_f[HALF-1:0], opnd_f[DW-1:HALF]}) == '0));
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] insn,
    input  logic [DW-1:0] file_rd,
    output logic [AW-1:0] file_addr,
    output logic [DW-1:0] res,
    output logic          wr_en,
    output logic          to_file,
    output logic [DW-1:0] w_out,
    output logic          z_out,
    output logic          c_out
);
    exu_ctl_t  ctl;
    exu_arch_t arch_d, arch_q;
    logic      alu_c;

    exu_decode u_dec (
        .opc (insn[IW-1:AW]),
        .ctl (ctl)
    );

    exu_alu u_alu (
        .op      (ctl.op),
        .opnd_f  (file_rd),
        .opnd_w  (arch_q.w),
        .lit     (insn[DW-1:0]),
        .bit_sel (insn[DW-1:DW-BW]),
        .c_in    (arch_q.c),
        .res     (res),
        .c_res   (alu_c)
    );

    assign file_addr = insn[AW-1:0];
    assign wr_en     = ctl.wr_en;
    assign to_file   = ctl.to_file;

    always_comb begin
        arch_d = arch_q;
        if (ctl.wr_en && !ctl.to_file) arch_d.w = res;
        if (ctl.z_upd)                 arch_d.z = (res == '0);
        if (ctl.c_upd)                 arch_d.c = alu_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arch_q <= '0;
        else        arch_q <= arch_d;
    end

    assign w_out = arch_q.w;
    assign z_out = arch_q.z;
    assign c_out = arch_q.c;

    // R9
    lit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:IW-4] == 4'hC) |=> (w_out == $past(insn[DW-1:0])));

    // R8
    bitop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:IW-3] == 3'b010) |=> ($stable(w_out) && $stable(z_out) && $stable(c_out)));

    // R7
    clrw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:AW] == 7'b0000010) |=> (w_out == '0 && z_out));

    // R2
    file_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && to_file) |=> $stable(w_out));

    // R10
    unused_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:IW-2] == 2'b10) |-> !wr_en ##1 ($stable(w_out) && $stable(z_out) && $stable(c_out)));

    // R5
    rot_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:IW-5] == 5'b00110) |=>
            (c_out == ($past(insn[IW-6]) ? $past(file_rd[DW-1]) : $past(file_rd[0]))));

    // R3
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[IW-1:IW-6] == 6'b000010) |=> (c_out == ($past(file_rd) >= $past(w_out))));
endmodule

// File: tb/sim_exu_top.sv
module sim_exu_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] insn = '0;
    logic [7:0]  file_rd = '0;
    logic [4:0]  file_addr;
    logic [7:0]  res;
    logic        wr_en, to_file;
    logic [7:0]  w_out;
    logic        z_out, c_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state
    int mw = 0, mz = 0, mc = 0;
    int e_we, e_file, e_res, n_w, n_z, n_c;
    string tag, prev_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    exu_top u0 (
        .clk(clk), .rst_n(rst_n), .insn(insn), .file_rd(file_rd),
        .file_addr(file_addr), .res(res), .wr_en(wr_en), .to_file(to_file),
        .w_out(w_out), .z_out(z_out), .c_out(c_out)
    );

    task automatic chk(input string t, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (insn %03h)", t, what, act, exp, insn);
        end
    endtask

    task automatic model(input logic [11:0] i, input logic [7:0] f);
        int a, r, b, k;
        bit zop, cop, valid;
        a = f; r = 0; zop = 0; cop = 0; valid = 1;
        e_we = 0; e_file = 0; e_res = 0;
        n_w = mw; n_z = mz; n_c = mc; tag = "R10";
        if (i[11:5] == 7'b0000001) begin
            r = mw; e_file = 1; tag = "R7";
        end else if (i[11:6] == 6'b000001) begin
            r = 0; e_file = i[5]; zop = 1; tag = "R7";
        end else if (i[11:9] == 3'b000 || (i[11:9] == 3'b001 && i[8:6] != 3'b011 && i[8:6] != 3'b111)) begin
            e_file = i[5];
            case (int'(i[11:6]))
                2:  begin r = (a - mw) & 255; cop = 1; n_c = (a >= mw); zop = 1; tag = "R3"; end
                7:  begin r = (a + mw) & 255; cop = 1; n_c = (a + mw > 255); zop = 1; tag = "R3"; end
                3:  begin r = (a + 255) & 255; zop = 1; tag = "R4"; end
                4:  begin r = a | mw; zop = 1; tag = "R4"; end
                5:  begin r = a & mw; zop = 1; tag = "R4"; end
                6:  begin r = a ^ mw; zop = 1; tag = "R4"; end
                8:  begin r = a; zop = 1; tag = "R4"; end
                9:  begin r = 255 - a; zop = 1; tag = "R4"; end
                10: begin r = (a + 1) & 255; zop = 1; tag = "R4"; end
                12: begin r = (mc * 128) + (a / 2); n_c = a % 2; tag = "R5"; end
                13: begin r = ((a * 2) & 255) + mc; n_c = a / 128; tag = "R5"; end
                14: begin r = ((a % 16) * 16) + (a / 16); tag = "R6"; end
                default: valid = 0;
            endcase
            if (cop) ;
        end else if (i[11:9] == 3'b010) begin
            b = 1 << i[7:5];
            r = i[8] ? (a | b) : (a & (255 - b));
            e_file = 1; tag = "R8";
        end else if (i[11:10] == 2'b11) begin
            k = i[7:0];
            case (int'(i[9:8]))
                0: r = k;
                1: begin r = k | mw; zop = 1; end
                2: begin r = k & mw; zop = 1; end
                default: begin r = k ^ mw; zop = 1; end
            endcase
            tag = "R9";
        end else begin
            valid = 0;
        end
        if (valid) begin
            e_we = 1; e_res = r;
            if (zop) n_z = (r == 0);
            if (e_file == 0) n_w = r;
        end else begin
            tag = "R10";
        end
    endtask

    task automatic check_regs();
        chk(prev_tag, "W", w_out, mw);
        chk(prev_tag, "zero", z_out, mz);
        chk(prev_tag, "carry", c_out, mc);
    endtask

    task automatic step(input logic [11:0] i, input logic [7:0] f);
        @(negedge clk);
        check_regs();
        insn = i; file_rd = f;
        #1;
        model(i, f);
        chk(tag, "wr_en", wr_en, e_we);
        chk("R2", "file_addr", file_addr, i[4:0]);
        if (e_we) begin
            chk(tag, "res", res, e_res);
            chk(tag, "to_file", to_file, e_file);
        end
        // R11: registered W holds its old value until the edge
        chk("R11", "W before edge", w_out, mw);
        mw = n_w; mz = n_z; mc = n_c; prev_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        prev_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "W", w_out, 0);
        chk("R1", "zero", z_out, 0);
        chk("R1", "carry", c_out, 0);
        chk("R1", "wr_en", wr_en, 0);
        rst_n = 1'b1;
        step(12'hC35, 8'h00);          // W = 35
        step(12'h1C4, 8'hD0);          // add to W: 105 -> W=05 C=1
        step(12'h0A7, 8'h05);          // sub to file: 0 -> Z=1 C=1
        step(12'h084, 8'h04);          // sub to W: 4-5 -> FF C=0
        step(12'h301, 8'h01);          // rotate right: C=0 in, C=1 out
        step(12'h341, 8'h80);          // rotate left with C=1
        step(12'h39F, 8'hA5);          // swap
        step(12'h05F, 8'h77);          // clear W, ignore low bits
        step(12'h03A, 8'h12);          // W to file
        step(12'h062, 8'h12);          // clear file
        step(12'h4E3, 8'hFF);          // clear bit 7
        step(12'h503, 8'h00);          // set bit 0
        step(12'hD00, 8'h00);          // OR literal 0 -> Z
        step(12'h2CF, 8'h01);          // unassigned
        step(12'h000, 8'h00);          // nop
        step(12'hA55, 8'h33);          // unassigned group
        for (int n = 0; n < N_RAND; n++)
            step(12'($urandom_range(0, 4095)), 8'($urandom_range(0, 255)));
        @(negedge clk);
        check_regs();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule